// File: doc/BRIEF.md
# Congestion-Driven Warp-Limit Controller

This block sits beside the warp scheduler of one GPU core. Its job is to decide how many warps that scheduler may issue from. When the GPU shares its memory system with latency-sensitive CPU cores, too many active warps congest DRAM and the on-chip network, and the CPU cores slow down. The controller counts three kinds of per-cycle events over a programmable sampling epoch:

- memory-congestion events;
- network-congestion events;
- scheduler stall cycles.

At the end of each epoch it places the memory count and the network count each into one of three levels, using programmable thresholds. From those two levels it picks one action on the active-warp limit: raise it by one, keep it, or lower it by one.

Two policies are available. The CPU-favouring policy cuts parallelism whenever either congestion level is high, and raises it only when both levels are low. The balanced policy also raises the limit when congestion is moderate but the scheduler is stalling heavily, because then the core has too few warps to hide latency. A two-bit bias setting moves the trade-off toward the CPU side. It scales the congestion thresholds down and makes the stall test harder to meet.

The result is a registered warp limit, bounded by 1 and a configured maximum, and a thermometer-coded issue-enable mask with one bit per warp slot. The scheduler's own selection among the enabled warps is outside this block.

Top module: `warp_limit_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after its release, `warp_limit` equals MAX_WARPS (48) and all MAX_WARPS bits of `issue_en` are 1.
- R2: At an epoch end, each congestion total is classified as follows, with boundaries inclusive at the upper threshold:
  - HIGH when the total is at or above the effective T2;
  - otherwise MEDIUM when the total is at or above the effective T1;
  - otherwise LOW.

  Memory uses `cfg_mem_t1`/`cfg_mem_t2`. Network uses `cfg_net_t1`/`cfg_net_t2`.
- R3: If either the memory level or the network level is HIGH at an epoch end, the limit drops by one, in both policies.
- R4: With `cfg_mode` = 1 (CPU-favouring), the limit rises by one when both levels are LOW, and is otherwise held unless R3 applies.
- R5: With `cfg_mode` = 0 (balanced), when neither level is HIGH the limit rises by one if both levels are LOW, or if the stall total is high. In any other case it is held.
- R6: Each effective congestion threshold is the programmed value shifted right by `cfg_bias` (0 = even, 3 = strongest CPU bias). The stall total is high when (stall total >> `cfg_bias`) >= `cfg_stall_thr`.
- R7: The limit saturates at a floor of 1 and a ceiling equal to `cfg_max_warps` clipped to the range 1..MAX_WARPS. The ceiling is applied at every epoch end, so a lowered ceiling pulls the limit down at the next epoch end.
- R8: An epoch lasts `cfg_epoch_len` cycles (0 counts as 1), and events in every cycle of the epoch are counted, including its last cycle. The totals start from zero in each new epoch. `warp_limit` changes only on the clock edge that closes an epoch, and the new value is visible from the next cycle.
- R9: Bit i of `issue_en` is 1 exactly when i < `warp_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| mem_evt | input | 1 | Memory-congestion event in this cycle |
| net_evt | input | 1 | Network-congestion event in this cycle |
| stall_evt | input | 1 | Scheduler stall cycle |
| cfg_mode | input | 1 | 0 = balanced policy, 1 = CPU-favouring policy |
| cfg_bias | input | 2 | Bias toward CPU benefit, 0 (even) to 3 (strong) |
| cfg_epoch_len | input | CNT_W | Epoch length in cycles |
| cfg_mem_t1 | input | CNT_W | Memory LOW/MEDIUM threshold |
| cfg_mem_t2 | input | CNT_W | Memory MEDIUM/HIGH threshold |
| cfg_net_t1 | input | CNT_W | Network LOW/MEDIUM threshold |
| cfg_net_t2 | input | CNT_W | Network MEDIUM/HIGH threshold |
| cfg_stall_thr | input | CNT_W | Stall-high threshold |
| cfg_max_warps | input | LIM_W | Requested limit ceiling |
| warp_limit | output | LIM_W | Current active-warp limit |
| issue_en | output | MAX_WARPS | Per-warp issue enable |

## Verification
The limit is a running sum of one-step actions, so one wrong classification or action leaves `warp_limit` off by one. The error shows one cycle after the epoch-end edge and does not go away, because every later value depends on it. A phase error in the epoch timer, or a counter that fails to clear, shows as a limit that moves a cycle early or late, or that moves the wrong way in an epoch with no events. A mask error shows at once in `issue_en` for the current limit.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2
  } act_e;

  typedef enum logic {
    MODE_BAL = 1'b0,
    MODE_CPU = 1'b1
  } mode_e;

endpackage

// File: rtl/wlc_epoch_timer.sv
module wlc_epoch_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len,
  output logic             epoch_end
);

  logic [CNT_W-1:0] ep_q;
  logic [CNT_W-1:0] ep_d;
  logic [CNT_W:0]   ep_plus;

  // a length of 0 or 1 closes an epoch every cycle
  always_comb begin
    ep_plus   = {1'b0, ep_q} + {{CNT_W{1'b0}}, 1'b1};
    epoch_end = (ep_plus >= {1'b0, len});
    ep_d      = epoch_end ? '0 : ep_plus[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ep_q <= '0;
    else        ep_q <= ep_d;
  end

endmodule

// File: rtl/wlc_evt_counter.sv
module wlc_evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  output logic [CNT_W-1:0] total
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    // total includes the current cycle's event, saturating
    if (&cnt_q) total = cnt_q;
    else        total = cnt_q + {{(CNT_W-1){1'b0}}, evt};
    cnt_d  = clr ? '0 : total;
    cnt_en = evt | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wlc_classifier.sv
module wlc_classifier
  import wlc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] t1,
  input  logic [CNT_W-1:0] t2,
  input  logic [1:0]       bias,
  output lvl_e             lvl
);

  logic [CNT_W-1:0] eff_t1;
  logic [CNT_W-1:0] eff_t2;

  always_comb begin
    eff_t1 = t1 >> bias;
    eff_t2 = t2 >> bias;
    if (cnt >= eff_t2)      lvl = LVL_HIGH;
    else if (cnt >= eff_t1) lvl = LVL_MED;
    else                    lvl = LVL_LOW;
  end

endmodule

// File: rtl/wlc_limit_ctrl.sv
module wlc_limit_ctrl
  import wlc_pkg::*;
#(
  parameter int MAX_WARPS = 48,
  parameter int LIM_W     = $clog2(MAX_WARPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 epoch_end,
  input  lvl_e                 mem_lvl,
  input  lvl_e                 net_lvl,
  input  logic                 stall_high,
  input  mode_e                mode,
  input  logic [LIM_W-1:0]     cfg_max,
  output logic [LIM_W-1:0]     limit_q,
  output logic [MAX_WARPS-1:0] issue_en
);

  localparam logic [LIM_W-1:0] LIM_MAX = LIM_W'(MAX_WARPS);
  localparam logic [LIM_W:0]   ONE_W   = (LIM_W+1)'(1);

  act_e             act;
  logic [LIM_W-1:0] cap;
  logic [LIM_W:0]   stepped;
  logic [LIM_W-1:0] limit_d;

  // action selection
  always_comb begin
    act = ACT_HOLD;
    if (mem_lvl == LVL_HIGH || net_lvl == LVL_HIGH)   act = ACT_DEC;
    else if (mem_lvl == LVL_LOW && net_lvl == LVL_LOW) act = ACT_INC;
    else if (mode == MODE_BAL && stall_high)          act = ACT_INC;
  end

  // step and clamp
  always_comb begin
    if (cfg_max > LIM_MAX)   cap = LIM_MAX;
    else if (cfg_max == '0)  cap = {{(LIM_W-1){1'b0}}, 1'b1};
    else                     cap = cfg_max;
    case (act)
      ACT_INC: stepped = {1'b0, limit_q} + ONE_W;
      ACT_DEC: stepped = {1'b0, limit_q} - ONE_W;
      default: stepped = {1'b0, limit_q};
    endcase
    if (stepped < ONE_W)               limit_d = {{(LIM_W-1){1'b0}}, 1'b1};
    else if (stepped > {1'b0, cap})    limit_d = cap;
    else                               limit_d = stepped[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         limit_q <= LIM_MAX;
    else if (epoch_end) limit_q <= limit_d;
  end

  // thermometer mask
  for (genvar i = 0; i < MAX_WARPS; i++) begin : g_mask
    localparam logic [LIM_W:0] IDX = (LIM_W+1)'(i);
    assign issue_en[i] = ({1'b0, limit_q} > IDX);
  end

  // R7
  limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q >= {{(LIM_W-1){1'b0}}, 1'b1}) && (limit_q <= LIM_MAX));

  // R8
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_end |=> $stable(limit_q));

  // R3
  high_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_end && (mem_lvl == LVL_HIGH || net_lvl == LVL_HIGH)) |=> (limit_q <= $past(limit_q)));

  // R4
  cpu_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_end && mode == MODE_CPU && !(mem_lvl == LVL_LOW && net_lvl == LVL_LOW))
      |=> (limit_q <= $past(limit_q)));

  // R9
  mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issue_en) == int'(limit_q));

endmodule

// File: rtl/warp_limit_ctrl.sv
module warp_limit_ctrl
  import wlc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_WARPS = 48,
  parameter int LIM_W     = $clog2(MAX_WARPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mem_evt,
  input  logic                 net_evt,
  input  logic                 stall_evt,
  input  logic                 cfg_mode,
  input  logic [1:0]           cfg_bias,
  input  logic [CNT_W-1:0]     cfg_epoch_len,
  input  logic [CNT_W-1:0]     cfg_mem_t1,
  input  logic [CNT_W-1:0]     cfg_mem_t2,
  input  logic [CNT_W-1:0]     cfg_net_t1,
  input  logic [CNT_W-1:0]     cfg_net_t2,
  input  logic [CNT_W-1:0]     cfg_stall_thr,
  input  logic [LIM_W-1:0]     cfg_max_warps,
  output logic [LIM_W-1:0]     warp_limit,
  output logic [MAX_WARPS-1:0] issue_en
);

  localparam int NUM_SRC = 3;

  logic             epoch_end;
  logic [NUM_SRC-1:0] evts;
  logic [CNT_W-1:0] totals [NUM_SRC];
  logic [CNT_W-1:0] stall_scaled;
  logic             stall_high;
  lvl_e             mem_lvl;
  lvl_e             net_lvl;

  assign evts = {stall_evt, net_evt, mem_evt};

  wlc_epoch_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .len       (cfg_epoch_len),
    .epoch_end (epoch_end)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cnt
    wlc_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evts[s]),
      .clr   (epoch_end),
      .total (totals[s])
    );
  end

  wlc_classifier #(.CNT_W(CNT_W)) u_mem_cls (
    .cnt  (totals[0]),
    .t1   (cfg_mem_t1),
    .t2   (cfg_mem_t2),
    .bias (cfg_bias),
    .lvl  (mem_lvl)
  );

  wlc_classifier #(.CNT_W(CNT_W)) u_net_cls (
    .cnt  (totals[1]),
    .t1   (cfg_net_t1),
    .t2   (cfg_net_t2),
    .bias (cfg_bias),
    .lvl  (net_lvl)
  );

  // R6: stall test tightened by the bias
  always_comb begin
    stall_scaled = totals[2] >> cfg_bias;
    stall_high   = (stall_scaled >= cfg_stall_thr);
  end

  wlc_limit_ctrl #(.MAX_WARPS(MAX_WARPS), .LIM_W(LIM_W)) u_limit (
    .clk        (clk),
    .rst_n      (rst_n),
    .epoch_end  (epoch_end),
    .mem_lvl    (mem_lvl),
    .net_lvl    (net_lvl),
    .stall_high (stall_high),
    .mode       (mode_e'(cfg_mode)),
    .cfg_max    (cfg_max_warps),
    .limit_q    (warp_limit),
    .issue_en   (issue_en)
  );

endmodule

// File: tb/tb_warp_limit_ctrl.sv
module tb_warp_limit_ctrl;

  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int MAXW  = 48;
  localparam int LIM_W = 6;
  localparam int ELEN  = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mem_evt, net_evt, stall_evt;
  logic             cfg_mode;
  logic [1:0]       cfg_bias;
  logic [CNT_W-1:0] cfg_epoch_len, cfg_mem_t1, cfg_mem_t2, cfg_net_t1, cfg_net_t2, cfg_stall_thr;
  logic [LIM_W-1:0] cfg_max_warps;
  logic [LIM_W-1:0] warp_limit;
  logic [MAXW-1:0]  issue_en;

  int checks = 0;
  int errors = 0;
  int exp_lim;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  warp_limit_ctrl #(.CNT_W(CNT_W), .MAX_WARPS(MAXW), .LIM_W(LIM_W)) dut (
    .clk(clk), .rst_n(rst_n), .mem_evt(mem_evt), .net_evt(net_evt), .stall_evt(stall_evt),
    .cfg_mode(cfg_mode), .cfg_bias(cfg_bias), .cfg_epoch_len(cfg_epoch_len),
    .cfg_mem_t1(cfg_mem_t1), .cfg_mem_t2(cfg_mem_t2), .cfg_net_t1(cfg_net_t1),
    .cfg_net_t2(cfg_net_t2), .cfg_stall_thr(cfg_stall_thr), .cfg_max_warps(cfg_max_warps),
    .warp_limit(warp_limit), .issue_en(issue_en)
  );

  // act: 0 hold, 1 raise, 2 lower
  typedef struct packed {
    logic       mode;
    logic [1:0] bias;
    logic [4:0] mem;
    logic [4:0] net;
    logic [4:0] stall;
    logic [1:0] act;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 5'd12, 5'd0,  5'd0,  2'd2},  // R3 mem high
    '{1'b1, 2'd0, 5'd0,  5'd11, 5'd0,  2'd2},  // R3 net high
    '{1'b1, 2'd0, 5'd5,  5'd5,  5'd0,  2'd0},  // R4 med/med
    '{1'b1, 2'd0, 5'd5,  5'd0,  5'd0,  2'd0},  // R4 med/low
    '{1'b1, 2'd0, 5'd0,  5'd0,  5'd0,  2'd1},  // R4 low/low
    '{1'b0, 2'd0, 5'd5,  5'd5,  5'd9,  2'd1},  // R5 stall high
    '{1'b0, 2'd0, 5'd5,  5'd5,  5'd7,  2'd0},  // R5 stall low
    '{1'b0, 2'd0, 5'd12, 5'd0,  5'd15, 2'd2},  // R3 balanced
    '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  2'd1},  // R5 low/low
    '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  2'd1},  // R7 ceiling
    '{1'b1, 2'd2, 5'd2,  5'd0,  5'd0,  2'd2},  // R6 bias lowers T2
    '{1'b1, 2'd1, 5'd3,  5'd0,  5'd0,  2'd0},  // R6 bias medium
    '{1'b0, 2'd1, 5'd3,  5'd0,  5'd15, 2'd0},  // R6 stall scaled below
    '{1'b0, 2'd1, 5'd3,  5'd0,  5'd16, 2'd1},  // R6 stall scaled at thr
    '{1'b0, 2'd3, 5'd0,  5'd0,  5'd0,  2'd0},  // R6 bias 3: zero is medium
    '{1'b1, 2'd0, 5'd10, 5'd0,  5'd0,  2'd2},  // R2 at T2
    '{1'b1, 2'd0, 5'd9,  5'd3,  5'd0,  2'd0},  // R2 below T2
    '{1'b1, 2'd0, 5'd3,  5'd3,  5'd0,  2'd1},  // R2 below T1
    '{1'b1, 2'd0, 5'd4,  5'd0,  5'd0,  2'd0}   // R2 at T1
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap_of(input int m);
    if (m > MAXW) return MAXW;
    if (m < 1) return 1;
    return m;
  endfunction

  task automatic check_mask(input string req);
    logic [MAXW-1:0] em;
    for (int i = 0; i < MAXW; i++) em[i] = (i < exp_lim);
    checks++;
    if (issue_en !== em) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, issue_en, em);
    end
  endtask

  // runs one epoch starting at a negedge, ends at the negedge after the closing edge
  task automatic run_epoch(input logic mode, input logic [1:0] bias, input int m, input int n,
                           input int s, input int cyc, input bit late, input int act,
                           input string req);
    int prev;
    cfg_mode = mode;
    cfg_bias = bias;
    prev = int'(warp_limit);
    for (int c = 0; c < cyc; c++) begin
      mem_evt   = late ? (c >= cyc - m) : (c < m);
      net_evt   = (c < n);
      stall_evt = (c < s);
      if (c == cyc - 1 && cyc > 1) check("R8 limit stable inside epoch", int'(warp_limit), prev);
      @(posedge clk);
      @(negedge clk);
    end
    mem_evt = 0; net_evt = 0; stall_evt = 0;
    if (act == 1) exp_lim = exp_lim + 1;
    else if (act == 2) exp_lim = exp_lim - 1;
    if (exp_lim < 1) exp_lim = 1;
    if (exp_lim > cap_of(int'(cfg_max_warps))) exp_lim = cap_of(int'(cfg_max_warps));
    check(req, int'(warp_limit), exp_lim);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    mem_evt = 0; net_evt = 0; stall_evt = 0;
    cfg_mode = 0; cfg_bias = 0;
    cfg_epoch_len = CNT_W'(ELEN);
    cfg_mem_t1 = 4; cfg_mem_t2 = 10;
    cfg_net_t1 = 4; cfg_net_t2 = 10;
    cfg_stall_thr = 8;
    cfg_max_warps = LIM_W'(MAXW);
    exp_lim = MAXW;
    repeat (3) @(negedge clk);
    check("R1 reset limit", int'(warp_limit), MAXW);
    check_mask("R1 reset mask");
    rst_n = 1;
    check("R1 limit at release", int'(warp_limit), MAXW);

    for (int v = 0; v < NV; v++)
      run_epoch(TBL[v].mode, TBL[v].bias, int'(TBL[v].mem), int'(TBL[v].net),
                int'(TBL[v].stall), ELEN, 1'b0, int'(TBL[v].act), $sformatf("R2-table vector %0d", v));

    // R8: events in the final cycles, including the last one, are counted
    run_epoch(1'b1, 2'd0, 10, 0, 0, ELEN, 1'b1, 2, "R8 late events reach T2");
    // R8: counters cleared, an empty epoch raises
    run_epoch(1'b1, 2'd0, 0, 0, 0, ELEN, 1'b0, 1, "R8 counters cleared");
    check_mask("R9 mask at full limit");

    // R7: lowered ceiling and floor
    cfg_max_warps = 2;
    run_epoch(1'b1, 2'd0, 0, 0, 0, ELEN, 1'b0, 1, "R7 ceiling pulls limit down");
    check_mask("R9 mask at 2");
    run_epoch(1'b1, 2'd0, 12, 0, 0, ELEN, 1'b0, 2, "R7 lower to 1");
    run_epoch(1'b1, 2'd0, 12, 0, 0, ELEN, 1'b0, 2, "R7 floor holds at 1");
    check_mask("R9 mask at 1");
    cfg_max_warps = 0;
    run_epoch(1'b1, 2'd0, 0, 0, 0, ELEN, 1'b0, 1, "R7 zero ceiling counts as 1");
    cfg_max_warps = 60;
    run_epoch(1'b1, 2'd0, 0, 0, 0, ELEN, 1'b0, 1, "R7 oversize ceiling");

    // R8: shorter epoch, then length 0 counts as 1
    cfg_epoch_len = 5;
    run_epoch(1'b1, 2'd0, 0, 0, 0, 5, 1'b0, 1, "R8 five-cycle epoch");
    cfg_epoch_len = 0;
    run_epoch(1'b1, 2'd0, 0, 0, 0, 1, 1'b0, 1, "R8 zero length epoch");
    run_epoch(1'b1, 2'd0, 0, 0, 0, 1, 1'b0, 1, "R8 every cycle is an epoch");
    check_mask("R9 mask at 5");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule